// File: doc/BRIEF.md
# Aligned Quadword Load/Store Sequencer

This block carries out 128-bit register loads and stores over a memory port that is only 64 bits wide. A request gives a base address, a signed offset, a register index and, for a store, the 128-bit register value. The block adds the sign-extended offset to the base and clears the four lowest address bits, so every access falls on a 16-byte boundary. Misalignment never raises a fault. The quadword then moves as two ordered 64-bit beats: the lower half first, then the upper half.

For a load, the two returned beats are joined into one 128-bit value and handed back with a one-cycle register write strobe. A load aimed at register index 0 is dropped: it makes no memory access and no write. A store from register index 0 still runs, and it writes zeros to both beats whatever is on the data input.

The sequencer has four states. QW_IDLE accepts a request. QW_BEAT_LO issues the first beat. QW_BEAT_HI issues the second beat. QW_DONE presents the load result.
- QW_IDLE → QW_BEAT_LO when a valid request arrives that is not a load to index 0.
- QW_BEAT_LO → QW_BEAT_HI on memory ready.
- QW_BEAT_HI → QW_DONE on memory ready.
- QW_DONE → QW_IDLE always.

Each beat state waits for as many cycles as memory ready stays low.

Top module: `qword_mover`

## Requirements
- R1: The first beat's address is base plus the sign-extended offset, with bits [3:0] forced to zero.
- R2: The first beat moves register bits [63:0]. A store drives them on the write data. A load places the first returned beat in result bits [63:0].
- R3: The second beat is issued only after the first beat's ready. Its address is the aligned address plus 8, and it moves register bits [127:64].
- R4: A load (store flag 0) to register index 0 causes no memory request, no write strobe, and leaves busy low.
- R5: A store from register index 0 writes zero on both beats, whatever the write data input holds.
- R6: While ready is low, a beat holds the memory request, address, write enable and write data unchanged.
- R7: After a load's second beat is accepted, the write strobe is high for exactly one cycle (the next cycle), carrying the requested index and the assembled 128-bit value. A store never raises the write strobe.
- R8: Busy is high from the cycle after acceptance until the sequencer returns to idle. A request presented while busy is ignored.
- R9: During and after reset, busy, the memory request and the write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_base | input | ADDR_W | Base address |
| req_offset | input | OFS_W | Signed offset |
| req_reg | input | REG_W | Register index |
| req_wdata | input | 2*BEAT_W | Register value for a store |
| busy | output | 1 | Sequencer not idle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat address |
| mem_wdata | output | BEAT_W | Beat write data |
| mem_ready | input | 1 | Memory completes the current beat this cycle |
| mem_rdata | input | BEAT_W | Read data, valid with ready |
| rf_we | output | 1 | Register write strobe (loads) |
| rf_idx | output | REG_W | Register index to write |
| rf_wdata | output | 2*BEAT_W | Assembled 128-bit load value |

## Verification
The assertions assume that memory answers a read combinationally: read data must be valid in the same cycle that ready is high. They also assume the request inputs are stable around each clock edge. The bench's behavioural memory returns data from its array for the presented address whenever it raises ready. It drives ready either constantly high or in a pseudo-random pattern. All request inputs change only on the falling edge. Requests presented during busy are driven for at most two cycles, which is shorter than the shortest transaction.

// File: rtl/qw_pkg.sv
package qw_pkg;
    typedef enum logic [1:0] {
        QW_IDLE    = 2'd0,
        QW_BEAT_LO = 2'd1,
        QW_BEAT_HI = 2'd2,
        QW_DONE    = 2'd3
    } qw_state_e;
endpackage

// File: rtl/qw_agu.sv
module qw_agu #(
    parameter int ADDR_W    = 32,
    parameter int OFS_W     = 16,
    parameter int ALIGN_LSB = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] aligned
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] eff;

    always_comb begin
        ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
        eff     = base + ofs_ext;
        aligned = {eff[ADDR_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
    end
endmodule

// File: rtl/qw_fsm.sv
module qw_fsm
    import qw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      mem_ready,
    output qw_state_e state
);
    qw_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= QW_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            QW_IDLE:    if (start)     state_nx = QW_BEAT_LO;
            QW_BEAT_LO: if (mem_ready) state_nx = QW_BEAT_HI;
            QW_BEAT_HI: if (mem_ready) state_nx = QW_DONE;
            QW_DONE:                   state_nx = QW_IDLE;
            default:                   state_nx = QW_IDLE;
        endcase
    end
endmodule

// File: rtl/qw_regs.sv
module qw_regs #(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 5,
    parameter int BEAT_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  store_in,
    input  logic [REG_W-1:0]      idx_in,
    input  logic [ADDR_W-1:0]     addr_in,
    input  logic [2*BEAT_W-1:0]   wdata_in,
    input  logic                  cap_lo,
    input  logic                  cap_hi,
    input  logic [BEAT_W-1:0]     rdata,
    output logic                  store_q,
    output logic [REG_W-1:0]      idx_q,
    output logic [ADDR_W-1:0]     addr_q,
    output logic [2*BEAT_W-1:0]   wdata_q,
    output logic [2*BEAT_W-1:0]   rdata_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= 1'b0;
            idx_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                store_q <= store_in;
                idx_q   <= idx_in;
                addr_q  <= addr_in;
                wdata_q <= (idx_in == '0) ? '0 : wdata_in;
            end
            if (cap_lo) rdata_q[BEAT_W-1:0]        <= rdata;
            if (cap_hi) rdata_q[2*BEAT_W-1:BEAT_W] <= rdata;
        end
    end
endmodule

// File: rtl/qword_mover.sv
module qword_mover
    import qw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16,
    parameter int REG_W  = 5,
    parameter int BEAT_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [OFS_W-1:0]    req_offset,
    input  logic [REG_W-1:0]    req_reg,
    input  logic [2*BEAT_W-1:0] req_wdata,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BEAT_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic [BEAT_W-1:0]   mem_rdata,
    output logic                rf_we,
    output logic [REG_W-1:0]    rf_idx,
    output logic [2*BEAT_W-1:0] rf_wdata
);
    localparam int QW_W      = 2 * BEAT_W;
    localparam int ALIGN_LSB = $clog2(QW_W / 8);
    localparam int HALF_STEP = BEAT_W / 8;

    qw_state_e           state;
    logic                start;
    logic                cap_lo;
    logic                cap_hi;
    logic [ADDR_W-1:0]   aligned;
    logic                store_q;
    logic [REG_W-1:0]    idx_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [QW_W-1:0]     wdata_q;
    logic [QW_W-1:0]     rdata_q;

    // A load into index 0 is dropped before it reaches the sequencer.
    assign start  = req_valid && (state == QW_IDLE) && (req_store || (req_reg != '0));
    assign cap_lo = (state == QW_BEAT_LO) && mem_ready && !store_q;
    assign cap_hi = (state == QW_BEAT_HI) && mem_ready && !store_q;

    qw_agu #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .ALIGN_LSB(ALIGN_LSB)) u_agu (
        .base    (req_base),
        .offset  (req_offset),
        .aligned (aligned)
    );

    qw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_ready (mem_ready),
        .state     (state)
    );

    qw_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .BEAT_W(BEAT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .store_in (req_store),
        .idx_in   (req_reg),
        .addr_in  (aligned),
        .wdata_in (req_wdata),
        .cap_lo   (cap_lo),
        .cap_hi   (cap_hi),
        .rdata    (mem_rdata),
        .store_q  (store_q),
        .idx_q    (idx_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .rdata_q  (rdata_q)
    );

    always_comb begin
        busy      = 1'b1;
        mem_req   = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = wdata_q[BEAT_W-1:0];
        rf_we     = 1'b0;
        unique case (state)
            QW_IDLE:    busy = 1'b0;
            QW_BEAT_LO: mem_req = 1'b1;
            QW_BEAT_HI: begin
                mem_req   = 1'b1;
                mem_addr  = addr_q + ADDR_W'(HALF_STEP);
                mem_wdata = wdata_q[QW_W-1:BEAT_W];
            end
            QW_DONE:    rf_we = !store_q;
            default:    busy = 1'b0;
        endcase
        mem_we   = mem_req && store_q;
        rf_idx   = idx_q;
        rf_wdata = rdata_q;
    end
endmodule

// File: rtl/qw_chk.sv
module qw_chk #(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 5,
    parameter int BEAT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [REG_W-1:0]  req_reg,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BEAT_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              rf_we
);
    localparam int ALIGN_LSB = $clog2(2 * BEAT_W / 8);
    localparam int HALF_STEP = BEAT_W / 8;

    a_r1_first_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (mem_addr[ALIGN_LSB-1:0] == '0));

    a_r3_second_beat_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_addr[ALIGN_LSB-1:0] == '0)
        |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(HALF_STEP)));

    a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    a_r7_strobe_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_addr[ALIGN_LSB-1:0] != '0)
        |=> (!mem_req && (rf_we == !$past(mem_we))));

    a_r4_null_load_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_store && req_reg == '0) |=> !busy);

    a_r8_busy_covers_beats: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rf_we) |-> busy);
endmodule

bind qword_mover qw_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .BEAT_W(BEAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .req_reg   (req_reg),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .rf_we     (rf_we)
);

// File: tb/qword_mover_tb.sv
module qword_mover_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_store = 1'b0;
    logic [31:0]  req_base = '0;
    logic [15:0]  req_offset = '0;
    logic [4:0]   req_reg = '0;
    logic [127:0] req_wdata = '0;
    logic         busy, mem_req, mem_we, rf_we;
    logic [31:0]  mem_addr;
    logic [63:0]  mem_wdata, mem_rdata;
    logic         mem_ready = 1'b1;
    logic [4:0]   rf_idx;
    logic [127:0] rf_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit rdy_rand = 1'b0;
    bit run_cmp = 1'b0;
    int exp_loads = 0;
    int seen_loads = 0;

    logic [63:0] mem [0:63];
    logic [63:0] ref_mem [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    qword_mover u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_base(req_base), .req_offset(req_offset), .req_reg(req_reg),
        .req_wdata(req_wdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata)
    );

    // behavioural memory
    assign mem_rdata = mem[mem_addr[8:3]];
    always @(posedge clk)
        if (mem_req && mem_ready && mem_we) mem[mem_addr[8:3]] = mem_wdata;
    always @(negedge clk)
        mem_ready = rdy_rand ? ($urandom % 3 != 0) : 1'b1;

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model: phase 0 idle, 1 first beat, 2 second beat, 3 result
    int           m_ph = 0;
    bit           m_st;
    logic [4:0]   m_idx;
    logic [31:0]  m_addr;
    logic [127:0] m_data;
    logic [127:0] m_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) m_ph = 0;
        else begin
            case (m_ph)
                0: if (req_valid && (req_store || req_reg != 0)) begin
                    m_st   = req_store;
                    m_idx  = req_reg;
                    m_addr = (req_base + 32'($signed(req_offset))) & 32'hFFFF_FFF0;
                    m_data = (req_reg == 0) ? 128'd0 : req_wdata;
                    m_ph   = 1;
                end
                1: if (mem_ready) begin
                    if (m_st) ref_mem[m_addr[8:3]] = m_data[63:0];
                    else m_rd[63:0] = ref_mem[m_addr[8:3]];
                    m_ph = 2;
                end
                2: if (mem_ready) begin
                    if (m_st) ref_mem[m_addr[8:3] + 6'd1] = m_data[127:64];
                    else m_rd[127:64] = ref_mem[m_addr[8:3] + 6'd1];
                    m_ph = 3;
                end
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            check("R8 busy", busy, m_ph != 0);
            check("R4/R6 mem_req", mem_req, m_ph == 1 || m_ph == 2);
            if (m_ph == 1 || m_ph == 2) begin
                check(m_ph == 1 ? "R1 addr" : "R3 addr", mem_addr,
                      m_ph == 1 ? m_addr : m_addr + 32'd8);
                check("R2 we", mem_we, m_st);
                if (m_st)
                    check("R5 wdata", mem_wdata, m_ph == 1 ? m_data[63:0] : m_data[127:64]);
            end
            check("R7 strobe", rf_we, m_ph == 3 && !m_st);
            if (m_ph == 3 && !m_st) begin
                check("R7 idx", rf_idx, m_idx);
                check("R2/R3 rdata", rf_wdata, m_rd);
            end
            if (rf_we) seen_loads++;
        end
    end

    task automatic issue(bit st, logic [31:0] b, logic [15:0] o, logic [4:0] r, logic [127:0] d);
        while (busy) @(negedge clk);
        req_store = st; req_base = b; req_offset = o; req_reg = r; req_wdata = d;
        req_valid = 1'b1;
        if (!st && r != 0) exp_loads++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 busy", busy, 0);
        check("R9 mem_req", mem_req, 0);
        check("R9 rf_we", rf_we, 0);
        rst_n = 1'b1;
        run_cmp = 1'b1;
        @(negedge clk);

        // R1 R2 R3: positive offset, always-ready memory
        issue(1, 32'h100, 16'd5, 5'd3, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
        drain();
        check("R2 low beat in memory", mem[6'h20], 64'h5555_6666_7777_8888);
        check("R3 high beat in memory", mem[6'h21], 64'h1111_2222_3333_4444);
        issue(0, 32'h10F, 16'd0, 5'd7, '0);
        drain();

        // negative offset with stalls (R1 R6)
        rdy_rand = 1'b1;
        issue(1, 32'h20F, 16'hFFF9, 5'd12, 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1234_5678);
        drain();
        issue(0, 32'h1F8, 16'h0009, 5'd31, '0);
        drain();

        // R5: store from index 0 writes zeros
        mem[8] = 64'hFFFF; mem[9] = 64'hFFFF; ref_mem[8] = 64'hFFFF; ref_mem[9] = 64'hFFFF;
        issue(1, 32'h40, 16'd3, 5'd0, {128{1'b1}});
        drain();
        check("R5 zero low beat", mem[8], 64'd0);
        check("R5 zero high beat", mem[9], 64'd0);

        // R4: load to index 0 does nothing
        issue(0, 32'h100, 16'd0, 5'd0, '0);
        check("R4 stays idle", busy, 0);
        check("R4 no access", mem_req, 0);
        check("R4 no strobe", rf_we, 0);

        // R8: requests while busy are ignored
        issue(1, 32'h180, 16'd0, 5'd4, 128'hA5A5);
        req_valid = 1'b1; req_store = 1'b1; req_base = 32'h1C0; req_reg = 5'd6;
        req_wdata = 128'h5A5A;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        drain();
        check("R8 ignored store", mem[6'h38], 64'd0);

        // mixed traffic
        for (int k = 0; k < 60; k++) begin
            rdy_rand = (k % 2 == 0);
            issue($urandom % 2, $urandom, 16'($urandom), 5'($urandom),
                  {$urandom, $urandom, $urandom, $urandom});
        end
        drain();
        check("R7 load strobe count", seen_loads, exp_loads);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule